// File: doc/BRIEF.md
# Serial Port Interrupt Aggregator

This block gathers the four interrupt causes of a serial port into a single registered interrupt line. Two causes are FIFO level conditions: the transmit FIFO at or below half full, and the receive FIFO at or above half full. They arrive as levels and appear in the status without any storage. The other two causes are receive timeout and receive overrun. They arrive as one-cycle pulses and are held in sticky flags until software writes a 1 to the matching bit of the clear register.

Software uses a small register bus with four word addresses: a mask register it can write and read back, a raw status view, a masked status view (raw AND mask), and a write-only clear register. The interrupt output is the OR of the masked status, sampled by a flop. It therefore follows any mask or status change one clock later.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mask reads 0, both sticky flags are 0 and `irq` is 0.
- R2: Writing address 0 stores the 4-bit mask. Reading address 0 returns it. Every register uses the bit order bit0 overrun, bit1 timeout, bit2 receive level, bit3 transmit level.
- R3: Reading address 1 returns the raw status in that bit order.
- R4: Raw bits 2 and 3 equal the `rx_lvl_hi` and `tx_lvl_lo` inputs in the same cycle and cannot be cleared by software.
- R5: A one-cycle pulse on `rx_ovr_evt` or `rx_tmo_evt` sets raw bit 0 or 1 at the next clock edge. The bit stays set after the pulse ends.
- R6: Writing address 3 with a 1 in bit 0 or bit 1 clears that sticky flag. Zero bits have no effect, and bits 2 and 3 of the write are ignored.
- R7: If a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: Reading address 2 returns raw status AND mask. A source whose mask bit is 0 never drives `irq`.
- R9: `irq` is registered and equals, one cycle later, the OR of the masked status bits.
- R10: Writes to addresses 1 and 2 change neither the mask nor the status. Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data (combinational on address) |
| tx_lvl_lo | input | 1 | Transmit FIFO at or below half full (level) |
| rx_lvl_hi | input | 1 | Receive FIFO at or above half full (level) |
| rx_tmo_evt | input | 1 | Receive timeout pulse |
| rx_ovr_evt | input | 1 | Receive overrun pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
A hardware set pulse on a sticky flag and a software clear write to that same flag can land in the same cycle. The bench provokes this by driving the overrun and timeout pulses together with a clearing write in one cycle. It then checks that both raw bits read back as 1. An exhaustive sweep of all 16 masks against all 16 source patterns judges the raw status, the masked status and `irq` against values computed arithmetically in the bench.

// File: rtl/sio_irq_pkg.sv
// Shared constants for the serial port interrupt aggregator.
// Assumes four sources in a fixed bit order that software decodes.
package sio_irq_pkg;
    localparam int NSRC    = 4;
    localparam int IDX_OVR = 0;
    localparam int IDX_TMO = 1;
    localparam int IDX_RXL = 2;
    localparam int IDX_TXL = 3;
    localparam int AW      = 2;

    // A 1 marks a source held in a flag that software clears
    localparam logic [NSRC-1:0] STICKY_MAP = 4'b0011;

    typedef enum logic [AW-1:0] {
        A_MASK = 2'd0,
        A_RAW  = 2'd1,
        A_MSKD = 2'd2,
        A_CLR  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/sio_irq_flag.sv
// Sticky event flag: set by a one-cycle pulse, cleared by a software strobe.
// Assumes set has priority over clear when both arrive in the same cycle.
module sio_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    // Hold the flag; a new event overrides a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assign q_o = q;
endmodule

// File: rtl/sio_irq_regs.sv
// Register bank: mask storage, clear decode and read multiplexer.
// Assumes a single-cycle write strobe and combinational reads.
module sio_irq_regs
    import sio_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [NSRC-1:0] wdata_i,
    input  logic [NSRC-1:0] raw_i,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] clr_o,
    output logic [NSRC-1:0] rdata_o
);
    logic [NSRC-1:0] mask_q;

    // Capture the mask on a write to its address
    always_ff @(posedge clk) begin
        if (!rst_n)                               mask_q <= '0;
        else if (wr_i && addr_i == AW'(A_MASK))   mask_q <= wdata_i;
    end

    // Clear strobes only reach sources that are sticky
    always_comb begin
        clr_o = '0;
        if (wr_i && addr_i == AW'(A_CLR)) clr_o = wdata_i & STICKY_MAP;
    end

    // Select the read view
    always_comb begin
        case (addr_i)
            AW'(A_MASK): rdata_o = mask_q;
            AW'(A_RAW):  rdata_o = raw_i;
            AW'(A_MSKD): rdata_o = raw_i & mask_q;
            default:     rdata_o = '0;
        endcase
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/sio_irq_ctrl.sv
// Serial port interrupt aggregator top. Builds raw status from level and
// pulse sources, applies the mask and registers the combined request.
// Assumes pulse inputs are one cycle wide and levels are synchronous.
module sio_irq_ctrl
    import sio_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    input  logic            tx_lvl_lo,
    input  logic            rx_lvl_hi,
    input  logic            rx_tmo_evt,
    input  logic            rx_ovr_evt,
    output logic            irq
);
    logic [NSRC-1:0] evt_vec;
    logic [NSRC-1:0] raw_stat;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] clr_vec;
    logic            irq_q;

    assign evt_vec[IDX_OVR] = rx_ovr_evt;
    assign evt_vec[IDX_TMO] = rx_tmo_evt;
    assign evt_vec[IDX_RXL] = rx_lvl_hi;
    assign evt_vec[IDX_TXL] = tx_lvl_lo;

    // Per source: a sticky flag or a direct level
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (STICKY_MAP[i]) begin : g_sticky
            sio_irq_flag u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (evt_vec[i]),
                .clr_i (clr_vec[i]),
                .q_o   (raw_stat[i])
            );
        end else begin : g_level
            assign raw_stat[i] = evt_vec[i];
        end
    end

    sio_irq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .raw_i   (raw_stat),
        .mask_o  (mask_q),
        .clr_o   (clr_vec),
        .rdata_o (bus_rdata)
    );

    // Register the combined request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(raw_stat & mask_q);
    end

    assign irq = irq_q;
endmodule

// File: rtl/sio_irq_chk.sv
// Property checker for the interrupt aggregator, bound to the top module.
// Assumes the bound signals keep the top's bit order.
module sio_irq_chk
    import sio_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [NSRC-1:0] bus_wdata,
    input logic            rx_tmo_evt,
    input logic            rx_ovr_evt,
    input logic [NSRC-1:0] raw_stat,
    input logic [NSRC-1:0] mask_q,
    input logic            irq
);
    logic clr_hit;
    assign clr_hit = bus_wr && bus_addr == AW'(A_CLR);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && !irq && raw_stat[1:0] == 2'b00));

    p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr_evt |=> raw_stat[IDX_OVR]);

    p_tmo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[IDX_TMO] && !(clr_hit && bus_wdata[IDX_TMO])) |=> raw_stat[IDX_TMO]);

    p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && bus_wdata[IDX_OVR] && !rx_ovr_evt) |=> !raw_stat[IDX_OVR]);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && bus_wdata[IDX_TMO] && rx_tmo_evt) |=> raw_stat[IDX_TMO]);

    p_masked_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq);

    p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(raw_stat & mask_q)));
endmodule

bind sio_irq_ctrl sio_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rx_tmo_evt (rx_tmo_evt),
    .rx_ovr_evt (rx_ovr_evt),
    .raw_stat   (raw_stat),
    .mask_q     (mask_q),
    .irq        (irq)
);

// File: tb/test_sio_irq_ctrl.sv
module test_sio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [3:0] bus_wdata = 4'd0;
    logic [3:0] bus_rdata;
    logic       tx_lvl_lo = 1'b0;
    logic       rx_lvl_hi = 1'b0;
    logic       rx_tmo_evt = 1'b0;
    logic       rx_ovr_evt = 1'b0;
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    sio_irq_ctrl i_sio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_lvl_lo(tx_lvl_lo),
        .rx_lvl_hi(rx_lvl_hi), .rx_tmo_evt(rx_tmo_evt),
        .rx_ovr_evt(rx_ovr_evt), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic logic [3:0] rd(input logic [1:0] a);
        bus_addr = a;
        return bus_rdata;
    endfunction

    task automatic rdchk(input string req, input logic [1:0] a, input logic [3:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rdchk("R1 mask", 2'd0, 4'h0);
        rdchk("R1 raw", 2'd1, 4'h0);
        chk("R1 irq", {3'b0, irq}, 4'h0);

        // R2 mask read-back sweep
        for (int m = 0; m < 16; m++) begin
            wr(2'd0, 4'(m));
            rdchk("R2 mask", 2'd0, 4'(m));
        end

        // Exhaustive sweep: R3 R4 R5 R8 R9
        for (int m = 0; m < 16; m++) begin
            for (int s = 0; s < 16; s++) begin
                logic [3:0] sv;
                sv = 4'(s);
                wr(2'd3, 4'h3);
                wr(2'd0, 4'(m));
                tx_lvl_lo = sv[3]; rx_lvl_hi = sv[2];
                rx_tmo_evt = sv[1]; rx_ovr_evt = sv[0];
                @(negedge clk);
                rx_tmo_evt = 1'b0; rx_ovr_evt = 1'b0;
                @(negedge clk);
                rdchk("R3 raw", 2'd1, sv);
                rdchk("R8 masked", 2'd2, sv & 4'(m));
                chk("R9 irq", {3'b0, irq}, {3'b0, |(sv & 4'(m))});
            end
        end

        // R5 hold over several idle cycles, R4 level drop is immediate
        wr(2'd3, 4'h3);
        tx_lvl_lo = 1'b1; rx_lvl_hi = 1'b1;
        rx_ovr_evt = 1'b1; rx_tmo_evt = 1'b1;
        @(negedge clk);
        rx_ovr_evt = 1'b0; rx_tmo_evt = 1'b0;
        repeat (4) @(negedge clk);
        rdchk("R5 hold", 2'd1, 4'hF);
        tx_lvl_lo = 1'b0;
        rdchk("R4 tx level same cycle", 2'd1, 4'h7);
        tx_lvl_lo = 1'b1;

        // R6 zero write no effect; level bits not clearable
        wr(2'd3, 4'h0);
        rdchk("R6 zero clear", 2'd1, 4'hF);
        wr(2'd3, 4'hC);
        rdchk("R6 level bits ignore clear", 2'd1, 4'hF);
        wr(2'd3, 4'h1);
        rdchk("R6 clear ovr only", 2'd1, 4'hE);
        wr(2'd3, 4'h2);
        rdchk("R6 clear tmo", 2'd1, 4'hC);

        // R7 set wins over same-cycle clear
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 4'h3;
        rx_ovr_evt = 1'b1; rx_tmo_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_ovr_evt = 1'b0; rx_tmo_evt = 1'b0;
        rdchk("R7 set wins", 2'd1, 4'hF);

        // R10 writes to status addresses ignored, clear reads zero
        wr(2'd0, 4'h5);
        wr(2'd1, 4'h0);
        wr(2'd2, 4'h0);
        rdchk("R10 mask kept", 2'd0, 4'h5);
        rdchk("R10 raw kept", 2'd1, 4'hF);
        rdchk("R10 clear reads 0", 2'd3, 4'h0);

        // R9 one-cycle latency after mask change
        wr(2'd0, 4'h0);
        @(negedge clk);
        chk("R8 mask off irq", {3'b0, irq}, 4'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 4'h8;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 irq not yet", {3'b0, irq}, 4'h0);
        @(negedge clk);
        chk("R9 irq one cycle later", {3'b0, irq}, 4'h1);

        // R1 reset again from a busy state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        tx_lvl_lo = 1'b0; rx_lvl_hi = 1'b0;
        rdchk("R1 mask after reset", 2'd0, 4'h0);
        rdchk("R1 raw after reset", 2'd1, 4'h0);
        chk("R1 irq after reset", {3'b0, irq}, 4'h0);
        void'(rd(2'd0));
        finish_run();
    end
endmodule